// File: doc/BRIEF.md
# Current-Sense Sample-and-Hold Controller

This block produces the digital control for one shared current-sense path that serves several output drivers. Software writes a 4-bit channel code into a select register. The code picks which driver is routed to the sense amplifier. From the high-side drive state of the selected driver, the block decides each cycle whether the analog stage follows the load current (track), keeps its last sample (hold), or reads as zero current (zero).

After each switch-on of the selected driver, the block flags the sense reading as not yet settled for a fixed blanking time. For each channel it also reports a read-only code for the sense-ratio class of that channel's mirror. Two of the channels change class with their bulb/LED mode input.

The analog sampling circuit and the current mirrors are outside this block. It only drives their controls. All outputs are registered, so they reflect the inputs sampled at the previous clock edge. The one exception is the ratio code, which also follows the live mode input.

Top module: `cs_sense_ctrl`

## Requirements
- R1: While reset is asserted, the outputs read as follows: mux select 0, select-valid 0, zero state, sense-ok 0 and ratio code 0.
- R2: A write strobe loads the channel code into the select register. The code takes effect one clock later. The codes 1, 4, 5, 6, 7, 8, 9, 10 and 11 are valid. For a valid code, the mux select output shows the code and select-valid is 1.
- R3: For an invalid code (0, 2, 3, 12 to 15), the mux select output is 0, select-valid is 0 and sense-ok is 0. The block also enters the zero state, even if some drive input is high.
- R4: The block is in track state in the cycle after one in which the selected channel's drive input is high. Drive input bit k-1 belongs to channel code k.
- R5: The block enters hold state when the selected channel's drive falls after tracking, with the selection unchanged. It stays in hold while that drive stays low.
- R6: A write of a different valid code whose channel drive is low puts the block in the zero state. If the new channel's drive is high in the same cycle, the block enters track instead.
- R7: The drive inputs of channels that are not selected have no effect on the state or on sense-ok.
- R8: After each switch-on of the sense path, sense-ok stays 0 for BLANK_CYC clock edges and then rises. A switch-on is a rising edge of the selected drive, or a selection that lands on a driven channel. Each new switch-on restarts this blanking time.
- R9: If the drive falls before blanking completes, sense-ok stays 0 through the hold that follows, until a later switch-on completes its blanking.
- R10: The ratio code is 0 for no valid selection. It is 1 (1/10000) for channels 1, 6 and 11, 2 (1/9200) for channels 4 and 5, and 3 (1/2000) for channels 9 and 10. Channels 7 and 8 read 1 in bulb mode and 3 in LED mode. Mode bit 0 belongs to channel 7 and bit 1 to channel 8, with 1 meaning LED.
- R11: Rewriting the code that is already selected changes neither the state nor the blanking count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we_i | input | 1 | Write strobe for the select register |
| sel_code_i | input | 4 | Channel code to load |
| drive_i | input | 11 | High-side on state per channel; bit k-1 is channel k |
| led_mode_i | input | 2 | LED mode of channels 7 (bit 0) and 8 (bit 1) |
| mux_sel_o | output | 4 | Selected channel code to the sense mux, 0 if none |
| sel_valid_o | output | 1 | Select register holds a monitor-capable code |
| track_o | output | 1 | Sense stage follows the load current |
| hold_o | output | 1 | Sense stage keeps its last sample |
| zero_o | output | 1 | Sense stage is reset to read zero current |
| sense_ok_o | output | 1 | Sense reading is settled and usable |
| ratio_cls_o | output | 2 | Sense-ratio class of the selected channel |

## Verification
The critical coincidence is a select write that lands in the same cycle as an edge on the drive of the newly chosen channel. In that cycle, the zero rule for a changed selection competes with the track rule and with the restart of blanking. The bench provokes this with a write to a channel whose drive rises on that same edge. It also writes a channel whose drive is low while the previous channel is still driven. The first case must give track with a fresh blanking count, and the second must give zero with sense-ok high. Every cycle of these sequences is compared against an arithmetic model of the requirements.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic [1:0] {
    SH_ZERO  = 2'd0,
    SH_TRACK = 2'd1,
    SH_HOLD  = 2'd2
  } sh_mode_e;

  localparam logic [1:0] RCLS_NONE = 2'd0;
  localparam logic [1:0] RCLS_LOW  = 2'd1;
  localparam logic [1:0] RCLS_MID  = 2'd2;
  localparam logic [1:0] RCLS_HIGH = 2'd3;

endpackage

// File: rtl/cs_sel_reg.sv
module cs_sel_reg #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned NCH   = 11,
  parameter logic [(1<<SEL_W)-1:0] MON_MASK  = 16'h0FF2,
  parameter logic [(1<<SEL_W)-1:0] MID_MASK  = 16'h0030,
  parameter logic [(1<<SEL_W)-1:0] HIGH_MASK = 16'h0600,
  parameter logic [(1<<SEL_W)-1:0] DUAL_MASK = 16'h0180,
  parameter int unsigned DUAL_BASE = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SEL_W-1:0] code_i,
  input  logic [NCH-1:0]   drive_i,
  input  logic [1:0]       led_i,
  output logic [SEL_W-1:0] sel_q,
  output logic             sel_valid_q,
  output logic             valid_d,
  output logic             on_d,
  output logic             chg_d,
  output logic [1:0]       ratio_o
);
  import cs_pkg::*;

  localparam int unsigned NCODE = 1 << SEL_W;

  logic [SEL_W-1:0] sel_d;
  logic [NCODE-1:0] drv_ext;

  // map drive bits onto code positions; unused codes see no drive
  genvar k;
  generate
    for (k = 0; k < NCODE; k++) begin : g_drv
      if (k >= 1 && k <= NCH) begin : g_used
        assign drv_ext[k] = drive_i[k-1];
      end else begin : g_unused
        assign drv_ext[k] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    sel_d   = we_i ? code_i : sel_q;
    chg_d   = we_i && (code_i != sel_q);
    valid_d = MON_MASK[sel_d];
    on_d    = valid_d && drv_ext[sel_d];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      sel_valid_q <= 1'b0;
    end else begin
      if (we_i) begin
        sel_q       <= code_i;
        sel_valid_q <= valid_d;
      end
    end
  end

  // ratio class of the selected channel
  logic led_bit;
  always_comb begin
    led_bit = (sel_q == SEL_W'(DUAL_BASE)) ? led_i[0] : led_i[1];
    if (!sel_valid_q)           ratio_o = RCLS_NONE;
    else if (DUAL_MASK[sel_q])  ratio_o = led_bit ? RCLS_HIGH : RCLS_LOW;
    else if (MID_MASK[sel_q])   ratio_o = RCLS_MID;
    else if (HIGH_MASK[sel_q])  ratio_o = RCLS_HIGH;
    else                        ratio_o = RCLS_LOW;
  end

  a_r2_valid_tracks_mask: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (sel_valid_q == MON_MASK[sel_q]));

  a_r10_none_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid_q |-> (ratio_o == RCLS_NONE));

  a_r11_same_code_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !chg_d) |=> $stable(sel_q));

endmodule

// File: rtl/cs_sh_fsm.sv
module cs_sh_fsm (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_d,
  input  logic             on_d,
  input  logic             chg_d,
  output cs_pkg::sh_mode_e mode_q
);
  import cs_pkg::*;

  sh_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!valid_d)                mode_d = SH_ZERO;
    else if (on_d)               mode_d = SH_TRACK;
    else if (chg_d)              mode_d = SH_ZERO;
    else if (mode_q == SH_TRACK) mode_d = SH_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SH_ZERO;
    else        mode_q <= mode_d;
  end

  a_r4_track_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    on_d |=> (mode_q == SH_TRACK));

  a_r5_hold_after_track: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SH_TRACK && valid_d && !on_d && !chg_d) |=> (mode_q == SH_HOLD));

  a_r6_zero_on_change_off: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_d && !on_d) |=> (mode_q == SH_ZERO));

  a_r3_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_d |=> (mode_q == SH_ZERO));

  a_r5_no_hold_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SH_ZERO) |=> (mode_q != SH_HOLD));

endmodule

// File: rtl/cs_blank_timer.sv
module cs_blank_timer #(
  parameter int unsigned BLANK_CYC = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_d,
  input  logic on_d,
  input  logic chg_d,
  output logic settled_o
);
  localparam int unsigned CNT_W = $clog2(BLANK_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             on_q;
  logic             rise;
  logic             cnt_en;

  always_comb begin
    rise   = on_d && (!on_q || chg_d);
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!valid_d)                       cnt_d = '0;
    else if (rise)                      cnt_d = CNT_W'(BLANK_CYC);
    else if (chg_d)                     cnt_d = '0;
    else if (on_d && (cnt_q != '0))     cnt_d = cnt_q - 1'b1;
    else                                cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else begin
      on_q <= on_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign settled_o = (cnt_q == '0);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BLANK_CYC));

  a_r8_restart_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !settled_o);

  a_r9_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_d && !on_d && !chg_d) |=> $stable(cnt_q));

endmodule

// File: rtl/cs_sense_ctrl.sv
module cs_sense_ctrl #(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned NCH       = 11,
  parameter int unsigned BLANK_CYC = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_code_i,
  input  logic [NCH-1:0]   drive_i,
  input  logic [1:0]       led_mode_i,
  output logic [SEL_W-1:0] mux_sel_o,
  output logic             sel_valid_o,
  output logic             track_o,
  output logic             hold_o,
  output logic             zero_o,
  output logic             sense_ok_o,
  output logic [1:0]       ratio_cls_o
);
  import cs_pkg::*;

  logic [SEL_W-1:0] sel_q;
  logic             sel_valid_q;
  logic             valid_d, on_d, chg_d;
  logic             settled;
  sh_mode_e         mode_q;

  cs_sel_reg #(.SEL_W(SEL_W), .NCH(NCH)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (sel_we_i),
    .code_i      (sel_code_i),
    .drive_i     (drive_i),
    .led_i       (led_mode_i),
    .sel_q       (sel_q),
    .sel_valid_q (sel_valid_q),
    .valid_d     (valid_d),
    .on_d        (on_d),
    .chg_d       (chg_d),
    .ratio_o     (ratio_cls_o)
  );

  cs_sh_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_d (valid_d),
    .on_d    (on_d),
    .chg_d   (chg_d),
    .mode_q  (mode_q)
  );

  cs_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_d   (valid_d),
    .on_d      (on_d),
    .chg_d     (chg_d),
    .settled_o (settled)
  );

  always_comb begin
    mux_sel_o   = sel_valid_q ? sel_q : '0;
    sel_valid_o = sel_valid_q;
    track_o     = (mode_q == SH_TRACK);
    hold_o      = (mode_q == SH_HOLD);
    zero_o      = (mode_q == SH_ZERO);
    sense_ok_o  = sel_valid_q && settled;
  end

  a_r4_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({track_o, hold_o, zero_o}));

  a_r3_invalid_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid_o |-> (zero_o && !sense_ok_o && mux_sel_o == '0));

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (zero_o && !sel_valid_o && !sense_ok_o));

endmodule

// File: tb/sim_cs_sense_ctrl.sv
module sim_cs_sense_ctrl;

  localparam int BLANK = 65;

  logic        clk;
  logic        rst_n;
  logic        sel_we_i;
  logic [3:0]  sel_code_i;
  logic [10:0] drive_i;
  logic [1:0]  led_mode_i;
  logic [3:0]  mux_sel_o;
  logic        sel_valid_o, track_o, hold_o, zero_o, sense_ok_o;
  logic [1:0]  ratio_cls_o;

  cs_sense_ctrl #(.BLANK_CYC(BLANK)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_we_i(sel_we_i), .sel_code_i(sel_code_i),
    .drive_i(drive_i), .led_mode_i(led_mode_i), .mux_sel_o(mux_sel_o),
    .sel_valid_o(sel_valid_o), .track_o(track_o), .hold_o(hold_o),
    .zero_o(zero_o), .sense_ok_o(sense_ok_o), .ratio_cls_o(ratio_cls_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // model state: mode 0 zero, 1 track, 2 hold
  int m_sel  = 0;
  int m_mode = 0;
  int m_cnt  = 0;
  bit m_on   = 1'b0;
  logic [10:0] cur_drv = '0;

  function automatic bit mon_ok(int c);
    return (c == 1) || (c >= 4 && c <= 11);
  endfunction

  function automatic int exp_ratio(int c, logic [1:0] led);
    if (!mon_ok(c)) return 0;
    if (c == 7) return led[0] ? 3 : 1;
    if (c == 8) return led[1] ? 3 : 1;
    if (c == 4 || c == 5) return 2;
    if (c == 9 || c == 10) return 3;
    return 1;
  endfunction

  function automatic int got_mode();
    if (track_o && !hold_o && !zero_o) return 1;
    if (hold_o && !track_o && !zero_o) return 2;
    if (zero_o && !track_o && !hold_o) return 0;
    return 7;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 mux_sel", int'(mux_sel_o), mon_ok(m_sel) ? m_sel : 0);
    chk("R2 sel_valid", int'(sel_valid_o), int'(mon_ok(m_sel)));
    chk("R4 mode", got_mode(), m_mode);
    chk("R8 sense_ok", int'(sense_ok_o), int'(mon_ok(m_sel) && m_cnt == 0));
    chk("R10 ratio", int'(ratio_cls_o), exp_ratio(m_sel, led_mode_i));
  endtask

  // one clock: inputs applied now (after a falling edge), model updated at the edge
  task automatic step(input bit we, input int code, input logic [10:0] drv);
    int  sd;
    bit  chg, vd, ond;
    sel_we_i   = we;
    sel_code_i = 4'(code);
    drive_i    = drv;
    cur_drv    = drv;
    @(posedge clk);
    sd  = we ? code : m_sel;
    chg = we && (code != m_sel);
    vd  = mon_ok(sd);
    ond = vd && drv[sd-1 < 0 ? 0 : sd-1] && (sd >= 1);
    if (!vd)              m_mode = 0;
    else if (ond)         m_mode = 1;
    else if (chg)         m_mode = 0;
    else if (m_mode == 1) m_mode = 2;
    if (!vd)                          m_cnt = 0;
    else if (ond && (!m_on || chg))   m_cnt = BLANK;
    else if (chg)                     m_cnt = 0;
    else if (ond && m_cnt != 0)       m_cnt = m_cnt - 1;
    m_on  = ond;
    m_sel = sd;
    @(negedge clk);
    sel_we_i = 1'b0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, cur_drv);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel_we_i = 1'b0; sel_code_i = '0; drive_i = '0; led_mode_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset outputs
    chk("R1 mux_sel", int'(mux_sel_o), 0);
    chk("R1 sel_valid", int'(sel_valid_o), 0);
    chk("R1 zero", int'(zero_o), 1);
    chk("R1 sense_ok", int'(sense_ok_o), 0);
    chk("R1 ratio", int'(ratio_cls_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 / R10: every code under every LED mode, no drive
    for (int c = 0; c < 16; c++) begin
      for (int l = 0; l < 4; l++) begin
        led_mode_i = 2'(l);
        step(1'b1, c, '0);
        chk("R3 valid flag for code", int'(sel_valid_o), int'(mon_ok(c)));
      end
    end
    led_mode_i = 2'b01;

    // per monitor-capable channel: track, blank, hold, ignore others, reselect
    for (int c = 1; c < 12; c++) begin
      if (mon_ok(c)) begin
        logic [10:0] own, other;
        int nxt;
        own   = 11'(1) << (c - 1);
        other = ~own;
        nxt   = (c == 11) ? 1 : ((c == 1) ? 4 : c + 1);
        step(1'b1, c, '0);
        step(1'b0, 0, own);
        chk("R4 track after drive high", got_mode(), 1);
        chk("R8 blanked after switch-on", int'(sense_ok_o), 0);
        idle(BLANK - 1);
        chk("R8 still blanked at last count", int'(sense_ok_o), 0);
        idle(1);
        chk("R8 settled after blank time", int'(sense_ok_o), 1);
        for (int i = 0; i < 4; i++) step(1'b0, 0, own | (i[0] ? other : '0));
        chk("R7 others ignored while tracking", got_mode(), 1);
        chk("R7 sense_ok kept", int'(sense_ok_o), 1);
        step(1'b0, 0, '0);
        chk("R5 hold after drive low", got_mode(), 2);
        for (int i = 0; i < 4; i++) step(1'b0, 0, i[0] ? other : '0);
        chk("R7 others ignored while holding", got_mode(), 2);
        step(1'b1, c, cur_drv & other);
        chk("R11 same code keeps hold", got_mode(), 2);
        chk("R11 same code keeps ok", int'(sense_ok_o), 1);
        step(1'b1, nxt, '0);
        chk("R6 zero on change to idle channel", got_mode(), 0);
        chk("R6 zero reads settled", int'(sense_ok_o), 1);
      end
    end

    // R8: rise mid-blank restarts the count
    step(1'b1, 1, '0);
    step(1'b0, 0, 11'h001);
    idle(30);
    step(1'b0, 0, '0);
    step(1'b0, 0, 11'h001);
    idle(BLANK - 2);
    chk("R8 restart keeps blank", int'(sense_ok_o), 0);
    idle(2);
    chk("R8 settles after restart", int'(sense_ok_o), 1);

    // R9: drive falls during blanking, hold stays unsettled
    step(1'b0, 0, '0);
    step(1'b0, 0, 11'h001);
    idle(10);
    step(1'b0, 0, '0);
    chk("R9 hold entered", got_mode(), 2);
    idle(BLANK + 5);
    chk("R9 unsettled hold", int'(sense_ok_o), 0);

    // R6: write lands on a channel whose drive rises in the same cycle
    step(1'b1, 4, 11'h008);
    chk("R6 same-cycle drive gives track", got_mode(), 1);
    chk("R6 same-cycle write blanks", int'(sense_ok_o), 0);
    idle(BLANK + 2);
    // change to idle channel while old one is still driven
    step(1'b1, 5, 11'h008);
    chk("R6 change while old driven gives zero", got_mode(), 0);
    chk("R6 zero settled", int'(sense_ok_o), 1);

    // R3: invalid code with everything driven
    step(1'b1, 2, 11'h7FF);
    chk("R3 invalid forces zero", got_mode(), 0);
    chk("R3 invalid mux", int'(mux_sel_o), 0);
    chk("R3 invalid not ok", int'(sense_ok_o), 0);
    idle(3);
    step(1'b1, 11, 11'h7FF);
    chk("R4 track from invalid to driven", got_mode(), 1);
    step(1'b1, 15, 11'h7FF);
    chk("R3 high invalid code zero", got_mode(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule